// File: doc/BRIEF.md
# DRAM ECC Error Logger

This block sits beside a memory controller's ECC checker and records what happened on the first ECC event, so that software can later find out which failure occurred, at which 4 KiB block, with which syndrome and on which of two channels. The checker drives two one-cycle strobes, one for a correctable and one for an uncorrectable error. Alongside the strobes it supplies the failing block address, an 8-bit syndrome and a channel bit. The logger keeps one set of captured details and two sticky flags.

The log has a priority rule. An uncorrectable error may replace details captured for a correctable one, but a correctable error never replaces anything already held. Software reads the registers through a small synchronous port. It clears a flag by writing a one to the flag's bit position. A command register holds one interrupt enable for each error class. The interrupt output is registered.

Top module: `ecc_err_log`

## Requirements
- R1: After synchronous reset every register reads zero and the interrupt output is low.
- R2: With both flags clear, a correctable strobe sets status bit 0 and captures the block address, syndrome and channel. The address register returns the block address in bits 31:12 and zero in bits 11:0.
- R3: An uncorrectable strobe sets status bit 7. If bit 7 was clear, the strobe also captures address, syndrome and channel.
- R4: An uncorrectable strobe while only bit 0 is set replaces the captured details and leaves bit 0 set.
- R5: A correctable strobe while either flag is set leaves address, syndrome and channel unchanged and only sets bit 0.
- R6: When both strobes arrive in the same cycle, the uncorrectable strobe's details are captured and both bits are set.
- R7: A write to the status register clears bit 0 and/or bit 7 where the written value has a one. A zero leaves the bit as it is. A strobe in the same cycle as a clear wins, so the flag stays set. All other status bits read zero.
- R8: Only command bit 7 (correctable enable) and bit 8 (uncorrectable enable) are writable. All other command bits read zero.
- R9: The interrupt output equals (bit 0 AND correctable enable) OR (bit 7 AND uncorrectable enable), evaluated one clock earlier.
- R10: Register select encoding: 0 status, 1 command, 2 address, 3 syndrome, 4 channel (bit 0 only). Selects 5 to 7 read zero.
- R11: While bit 7 is set, no strobe of either class changes the captured details.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_strobe_i | input | 1 | Correctable error seen this cycle |
| ue_strobe_i | input | 1 | Uncorrectable error seen this cycle |
| err_blk_i | input | 20 | Failing physical address bits 31:12 |
| err_syn_i | input | 8 | ECC syndrome of the failing access |
| err_chan_i | input | 1 | Channel of the failing access |
| reg_sel_i | input | 3 | Register select |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Registered error interrupt |

## Verification
The assertions check the following on every cycle:
- each strobe sets its flag on the next clock;
- once the uncorrectable flag is up, the log stays frozen;
- a correctable strobe never disturbs a held log;
- an unwritten flag never drops;
- the interrupt stays low when no flag is set.

Only the bench scenarios can show that the register map decodes correctly, which details end up in the log after overwrite and tie cases, that write-one-to-clear ignores zeros, and that the interrupt rises exactly one clock after an enable or flag change.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned PAGE_BITS = 12;
    localparam int unsigned BLK_W     = ADDR_W - PAGE_BITS;
    localparam int unsigned SYN_W     = 8;
    localparam int unsigned WDATA_W   = 16;
    localparam int unsigned RDATA_W   = 32;
    localparam int unsigned SEL_W     = 3;

    localparam int unsigned STAT_CE_BIT = 0;
    localparam int unsigned STAT_UE_BIT = 7;
    localparam int unsigned CMD_CE_BIT  = 7;
    localparam int unsigned CMD_UE_BIT  = 8;

    localparam logic [WDATA_W-1:0] CMD_MASK =
        WDATA_W'((1 << CMD_CE_BIT) | (1 << CMD_UE_BIT));

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CMD    = 3'd1,
        SEL_ADDR   = 3'd2,
        SEL_SYN    = 3'd3,
        SEL_CHAN   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [SYN_W-1:0] syn;
        logic             chan;
    } err_log_t;

    typedef struct packed {
        logic ce;
        logic ue;
    } err_flags_t;

    function automatic logic [RDATA_W-1:0] status_word(input err_flags_t f);
        logic [RDATA_W-1:0] w;
        w = '0;
        w[STAT_CE_BIT] = f.ce;
        w[STAT_UE_BIT] = f.ue;
        return w;
    endfunction

    function automatic logic [RDATA_W-1:0] addr_word(input logic [BLK_W-1:0] b);
        return {b, {PAGE_BITS{1'b0}}};
    endfunction
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
    import ecc_err_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic             ue_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [SYN_W-1:0] syn_i,
    input  logic             chan_i,
    input  logic             clr_ce_i,
    input  logic             clr_ue_i,
    output err_flags_t       flags_o,
    output err_log_t         log_o
);
    err_flags_t flags_q;
    err_log_t   log_q;
    logic       take_ue, take_ce;

    // Uncorrectable wins ties and may overwrite a correctable log.
    assign take_ue = ue_i && !flags_q.ue;
    assign take_ce = ce_i && !ue_i && !flags_q.ce && !flags_q.ue;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            log_q   <= '0;
        end else begin
            flags_q.ce <= ce_i | (flags_q.ce & ~clr_ce_i);
            flags_q.ue <= ue_i | (flags_q.ue & ~clr_ue_i);
            if (take_ue || take_ce) begin
                log_q.blk  <= blk_i;
                log_q.syn  <= syn_i;
                log_q.chan <= chan_i;
            end
        end
    end

    assign flags_o = flags_q;
    assign log_o   = log_q;

    AST_CE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ce_i |=> flags_q.ce); // R2
    AST_UE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ue_i |=> flags_q.ue); // R3
    AST_UE_FREEZES_LOG: assert property (@(posedge clk) disable iff (rst)
        flags_q.ue |=> $stable(log_q)); // R11
    AST_CE_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (flags_q.ce || flags_q.ue) && !ue_i |=> $stable(log_q)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags_q.ce && !clr_ce_i |=> flags_q.ce); // R7
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
    import ecc_err_log_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               wr_i,
    input  logic [WDATA_W-1:0] wdata_i,
    input  err_flags_t         flags_i,
    input  err_log_t           log_i,
    output logic               clr_ce_o,
    output logic               clr_ue_o,
    output logic               ce_en_o,
    output logic               ue_en_o,
    output logic [RDATA_W-1:0] rdata_o
);
    logic [WDATA_W-1:0] cmd_q;
    reg_sel_e           sel;

    assign sel      = reg_sel_e'(sel_i);
    assign clr_ce_o = wr_i && (sel == SEL_STATUS) && wdata_i[STAT_CE_BIT];
    assign clr_ue_o = wr_i && (sel == SEL_STATUS) && wdata_i[STAT_UE_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= '0;
        else if (wr_i && sel == SEL_CMD)
            cmd_q <= wdata_i & CMD_MASK;
    end

    assign ce_en_o = cmd_q[CMD_CE_BIT];
    assign ue_en_o = cmd_q[CMD_UE_BIT];

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_STATUS: rdata_o = status_word(flags_i);
            SEL_CMD:    rdata_o = RDATA_W'(cmd_q);
            SEL_ADDR:   rdata_o = addr_word(log_i.blk);
            SEL_SYN:    rdata_o = RDATA_W'(log_i.syn);
            SEL_CHAN:   rdata_o = RDATA_W'(log_i.chan);
            default:    rdata_o = '0;
        endcase
    end

    AST_CMD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_q & ~CMD_MASK) == '0); // R8
endmodule

// File: rtl/ecc_log_irq.sv
module ecc_log_irq
    import ecc_err_log_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t flags_i,
    input  logic       ce_en_i,
    input  logic       ue_en_i,
    output logic       irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (flags_i.ce & ce_en_i) | (flags_i.ue & ue_en_i);
    end

    assign irq_o = irq_q;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !flags_i.ce && !flags_i.ue |=> !irq_q); // R9
    AST_IRQ_UE: assert property (@(posedge clk) disable iff (rst)
        flags_i.ue && ue_en_i |=> irq_q); // R9
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_err_log_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_strobe_i,
    input  logic               ue_strobe_i,
    input  logic [BLK_W-1:0]   err_blk_i,
    input  logic [SYN_W-1:0]   err_syn_i,
    input  logic               err_chan_i,
    input  logic [SEL_W-1:0]   reg_sel_i,
    input  logic               reg_wr_i,
    input  logic [WDATA_W-1:0] reg_wdata_i,
    output logic [RDATA_W-1:0] reg_rdata_o,
    output logic               irq_o
);
    err_flags_t flags;
    err_log_t   log_st;
    logic       clr_ce, clr_ue, ce_en, ue_en;

    ecc_log_capture u_capture (
        .clk(clk), .rst(rst),
        .ce_i(ce_strobe_i), .ue_i(ue_strobe_i),
        .blk_i(err_blk_i), .syn_i(err_syn_i), .chan_i(err_chan_i),
        .clr_ce_i(clr_ce), .clr_ue_i(clr_ue),
        .flags_o(flags), .log_o(log_st)
    );

    ecc_log_regs u_regs (
        .clk(clk), .rst(rst),
        .sel_i(reg_sel_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
        .flags_i(flags), .log_i(log_st),
        .clr_ce_o(clr_ce), .clr_ue_o(clr_ue),
        .ce_en_o(ce_en), .ue_en_o(ue_en),
        .rdata_o(reg_rdata_o)
    );

    ecc_log_irq u_irq (
        .clk(clk), .rst(rst),
        .flags_i(flags), .ce_en_i(ce_en), .ue_en_i(ue_en),
        .irq_o(irq_o)
    );
endmodule

// File: tb/ecc_err_log_tb_top.sv
module ecc_err_log_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_strobe_i = 1'b0, ue_strobe_i = 1'b0;
    logic [19:0] err_blk_i = '0;
    logic [7:0]  err_syn_i = '0;
    logic        err_chan_i = 1'b0;
    logic [2:0]  reg_sel_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    ecc_err_log dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        reg_sel_i = sel;
        #1 v = reg_rdata_o;
    endtask

    task automatic rd_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        rd(sel, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel_i = sel; reg_wr_i = 1'b1; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic strobe(input logic ce, input logic ue, input logic [19:0] b,
                          input logic [7:0] s, input logic c);
        @(negedge clk);
        ce_strobe_i = ce; ue_strobe_i = ue;
        err_blk_i = b; err_syn_i = s; err_chan_i = c;
        @(negedge clk);
        ce_strobe_i = 1'b0; ue_strobe_i = 1'b0;
        err_blk_i = '0; err_syn_i = '0; err_chan_i = 1'b0;
    endtask

    task automatic log_check(input string req, input logic [31:0] st, input logic [19:0] b,
                             input logic [7:0] s, input logic c);
        rd_check(req, 3'd0, st);
        rd_check(req, 3'd2, {b, 12'h000});
        rd_check(req, 3'd3, {24'h0, s});
        rd_check(req, 3'd4, {31'h0, c});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) rd_check("R1 R10 reset", i[2:0], 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_ce_basic;
        strobe(1, 0, 20'h12345, 8'h5A, 1);
        log_check("R2 ce capture", 32'h1, 20'h12345, 8'h5A, 1);
        rd_check("R10 unused select", 3'd6, 32'h0);
    endtask

    task automatic t_ce_then_ue;
        strobe(1, 0, 20'hABCDE, 8'h11, 0);
        log_check("R5 ce ignored", 32'h1, 20'h12345, 8'h5A, 1);
        strobe(0, 1, 20'h0F0F0, 8'hC3, 0);
        log_check("R4 ue overwrite", 32'h81, 20'h0F0F0, 8'hC3, 0);
    endtask

    task automatic t_ue_hold;
        strobe(1, 0, 20'h11111, 8'h22, 1);
        log_check("R5 ce after ue", 32'h81, 20'h0F0F0, 8'hC3, 0);
        strobe(0, 1, 20'h33333, 8'h44, 1);
        log_check("R11 ue after ue", 32'h81, 20'h0F0F0, 8'hC3, 0);
    endtask

    task automatic t_w1c;
        wr(3'd0, 16'h0080);
        rd_check("R7 clear ue", 3'd0, 32'h1);
        wr(3'd0, 16'h0000);
        rd_check("R7 zero write", 3'd0, 32'h1);
        wr(3'd0, 16'hFFFF);
        rd_check("R7 clear all", 3'd0, 32'h0);
        strobe(1, 0, 20'hFEDCB, 8'h99, 1);
        log_check("R2 recapture", 32'h1, 20'hFEDCB, 8'h99, 1);
        wr(3'd0, 16'h0001);
        strobe(0, 1, 20'h00777, 8'h01, 0);
        log_check("R3 ue on clean", 32'h80, 20'h00777, 8'h01, 0);
        wr(3'd0, 16'h0081);
    endtask

    task automatic t_tie;
        strobe(1, 1, 20'h5A5A5, 8'hEE, 1);
        log_check("R6 tie", 32'h81, 20'h5A5A5, 8'hEE, 1);
        wr(3'd0, 16'h0081);
        rd_check("R7 clear both", 3'd0, 32'h0);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        ce_strobe_i = 1'b1; err_blk_i = 20'h00001; err_syn_i = 8'h07;
        reg_sel_i = 3'd0; reg_wr_i = 1'b1; reg_wdata_i = 16'h0001;
        @(negedge clk);
        ce_strobe_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        rd_check("R7 set wins", 3'd0, 32'h1);
        wr(3'd0, 16'h0001);
    endtask

    task automatic t_cmd_irq;
        wr(3'd1, 16'hFFFF);
        rd_check("R8 cmd mask", 3'd1, 32'h0180);
        wr(3'd1, 16'h0000);
        strobe(1, 0, 20'h00002, 8'h02, 0);
        @(negedge clk);
        check("R9 irq disabled", {31'h0, irq_o}, 32'h0);
        wr(3'd1, 16'h0080);
        check("R9 irq lag", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq ce", {31'h0, irq_o}, 32'h1);
        wr(3'd0, 16'h0001);
        @(negedge clk);
        check("R9 irq drop", {31'h0, irq_o}, 32'h0);
        wr(3'd1, 16'h0100);
        strobe(1, 0, 20'h00003, 8'h03, 0);
        @(negedge clk);
        check("R9 ce masked", {31'h0, irq_o}, 32'h0);
        strobe(0, 1, 20'h00004, 8'h04, 1);
        @(negedge clk);
        check("R9 irq ue", {31'h0, irq_o}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ce_basic();
        t_ce_then_ue();
        t_ue_hold();
        t_w1c();
        t_tie();
        t_set_wins();
        t_cmd_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule